// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block holds the operating mode of a bus-transceiver support device and drives the enables that follow from it. The modes are unpowered, fail-safe, normal, silent and sleep. It watches an enable pin, the transmit-data pin, an active-low local wake input, an ignition input, a reset-active flag and a power-good indication. From these it drives four enables: the supply regulator, the transceiver paths, the inhibit high-side switch and the watchdog. It also drives a two-bit fail-safe source code, which tells the host why the device is in fail-safe.

Power-up and any reset place the device in fail-safe. Enable high then moves it to normal. When enable falls, the transmit-data level decides between silent and sleep. Transmit data is sampled across a short guard window, so transmit data may fall a little after enable and still select sleep. From silent or sleep, only a new, debounced edge on the local wake input or the ignition input returns the device to fail-safe. The source code then records which input caused the wake.

All inputs are taken as synchronous to `clk`. Debounce lengths and the guard window are counted in clock cycles and set by parameters.

Top module: `xcvrModeCtrl`

## Requirements
- R1: `modeOut` encodes unpowered=0, fail-safe=1, normal=2, silent=3, sleep=4. The enables for each mode (regulator/transceiver/inhibit/watchdog) are: unpowered 0/0/0/0, fail-safe 1/0/1/1, normal 1/1/1/1, silent 1/0/0/0, sleep 0/0/0/0.
- R2: While `rstN` is low, or at any edge where `powerGood` is low, the mode is unpowered. The first edge with `powerGood` high moves unpowered to fail-safe and sets the source code to 1 (power-up).
- R3: In fail-safe, an edge with `enPin` high and `resetActive` low moves the device to normal. With `enPin` low it stays in fail-safe.
- R4: An edge with `resetActive` high forces fail-safe from normal, including during the guard window, and holds fail-safe. In silent and sleep, `resetActive` has no effect.
- R5: In normal, the first edge with `enPin` low opens a guard window. `txdIn` is sampled at that edge and at the next GUARD_CYC edges, and the mode reads normal throughout. At the GUARD_CYC-th following edge the mode becomes sleep if any sample was low, else silent.
- R6: If `enPin` is high again at any edge inside the guard window, the window is dropped and the device stays in normal.
- R7: `wakeNIn` low on WAKE_DEB consecutive edges, after having been high, creates a local wake event. In silent or sleep the mode becomes fail-safe on the edge after the event, with source code 2. A shorter low pulse does nothing.
- R8: `ignIn` high on IGN_DEB consecutive edges, after having been low, creates an ignition event. In silent or sleep the mode becomes fail-safe on the edge after the event, with source code 3.
- R9: A wake level held continuously from before silent or sleep was entered does not wake the device. This applies to `wakeNIn` held low and to `ignIn` held high.
- R10: When both events arrive on the same edge, the local wake wins and the source code is 2.
- R11: `fsSrc` reads 0 outside fail-safe. In fail-safe it shows the most recent source code. A reset-forced entry keeps the previous code.
- R12: Wake and ignition events have no effect on the mode outside silent and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supply present |
| resetActive | input | 1 | Reset-output-active flag |
| enPin | input | 1 | Enable pin level |
| txdIn | input | 1 | Transmit-data pin level |
| wakeNIn | input | 1 | Local wake input, active low |
| ignIn | input | 1 | Ignition input, active high |
| modeOut | output | 3 | Current mode code (R1) |
| regEn | output | 1 | Regulator enable |
| xcvrEn | output | 1 | Transceiver path enable |
| inhEn | output | 1 | Inhibit switch enable |
| wdEn | output | 1 | Watchdog enable |
| fsSrc | output | 2 | Fail-safe source code for the transmit/receive pins |

## Verification
The bench targets the edges of the sleep/silent decision.
- Transmit data falls two cycles after enable: a design that samples only at the enable edge would pick silent.
- Transmit data falls after the window has closed: a design whose window is too long would pick sleep.
- The window is cut short by enable rising again: a design that cannot abort would leave normal anyway.

Wake inputs get the same treatment.
- A low pulse one cycle shorter than the debounce must not wake.
- A level held from before sleep must not wake. An edge-blind design would bounce straight back to fail-safe.
- Two events land on the same edge, which exposes a wrong priority in the source code.
- A reset that arrives while asleep must not wake a design that applies reset in every mode.

// File: rtl/xcvrModePkg.sv
package xcvrModePkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_FAILSAFE = 3'd1,
    MODE_NORMAL   = 3'd2,
    MODE_SILENT   = 3'd3,
    MODE_SLEEP    = 3'd4
  } opMode_t;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_POWERUP = 2'd1,
    SRC_LOCAL   = 2'd2,
    SRC_IGNITE  = 2'd3
  } fsSrc_t;

  typedef enum logic [2:0] {
    ST_OFF, ST_FAILSAFE, ST_NORMAL, ST_GUARD, ST_SILENT, ST_SLEEP
  } ctlState_t;

  typedef struct packed {
    logic guardStart;
    logic guardClear;
  } ctlStrobe_t;

  typedef struct packed {
    logic wakeEvt;
    logic ignEvt;
    logic guardDone;
    logic sawTxdLow;
  } dpStatus_t;

endpackage

// File: rtl/modeDebounce.sv
module modeDebounce #(
  parameter int DEPTH = 5,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic evt
);
  localparam int CW = (DEPTH < 2) ? 1 : $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic active;
  logic armed;
  logic [CW-1:0] runCnt;

  generate
    if (ACTIVE_HIGH) begin : g_high
      assign active = sigIn;
    end else begin : g_low
      assign active = ~sigIn;
    end
  endgenerate

  // an event needs the idle level first, so a held level never fires twice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      runCnt <= '0;
      evt    <= 1'b0;
    end else if (!active) begin
      armed  <= 1'b1;
      runCnt <= '0;
      evt    <= 1'b0;
    end else if (armed) begin
      if (runCnt == LAST) begin
        evt    <= 1'b1;
        armed  <= 1'b0;
        runCnt <= '0;
      end else begin
        evt    <= 1'b0;
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      evt <= 1'b0;
    end
  end
endmodule

// File: rtl/modeDatapath.sv
module modeDatapath
  import xcvrModePkg::*;
#(
  parameter int WAKE_DEB  = 5,
  parameter int IGN_DEB   = 9,
  parameter int GUARD_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txdIn,
  input  logic       wakeNIn,
  input  logic       ignIn,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int GW = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] GLAST = GW'(GUARD_CYC);

  logic [GW-1:0] guardCnt;
  logic          guardSeen;
  logic          wakeEvt;
  logic          ignEvt;

  modeDebounce #(.DEPTH(WAKE_DEB), .ACTIVE_HIGH(1'b0)) u_wakeDeb (
    .clk(clk), .rstN(rstN), .sigIn(wakeNIn), .evt(wakeEvt)
  );

  modeDebounce #(.DEPTH(IGN_DEB), .ACTIVE_HIGH(1'b1)) u_ignDeb (
    .clk(clk), .rstN(rstN), .sigIn(ignIn), .evt(ignEvt)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      guardCnt  <= '0;
      guardSeen <= 1'b0;
    end else if (strobe.guardStart) begin
      guardCnt  <= GW'(1);
      guardSeen <= ~txdIn;
    end else if (strobe.guardClear) begin
      guardCnt  <= '0;
      guardSeen <= 1'b0;
    end else if (guardCnt != '0 && guardCnt != GLAST) begin
      guardCnt  <= guardCnt + 1'b1;
      guardSeen <= guardSeen | ~txdIn;
    end
  end

  always_comb begin
    status.wakeEvt   = wakeEvt;
    status.ignEvt    = ignEvt;
    status.guardDone = (guardCnt == GLAST);
    status.sawTxdLow = guardSeen | ~txdIn;
  end
endmodule

// File: rtl/modeControl.sv
module modeControl
  import xcvrModePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       resetActive,
  input  logic       enPin,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic [2:0] modeOut,
  output logic       regEn,
  output logic       xcvrEn,
  output logic       inhEn,
  output logic       wdEn,
  output logic [1:0] fsSrc
);
  ctlState_t state, stateNext;
  fsSrc_t    srcReg, srcNext;

  always_comb begin
    stateNext = state;
    srcNext   = srcReg;
    if (!powerGood) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          stateNext = ST_FAILSAFE;
          srcNext   = SRC_POWERUP;
        end
        ST_FAILSAFE: if (!resetActive && enPin) stateNext = ST_NORMAL;
        ST_NORMAL: begin
          if (resetActive)  stateNext = ST_FAILSAFE;
          else if (!enPin)  stateNext = ST_GUARD;
        end
        ST_GUARD: begin
          if (resetActive)           stateNext = ST_FAILSAFE;
          else if (enPin)            stateNext = ST_NORMAL;
          else if (status.guardDone) stateNext = status.sawTxdLow ? ST_SLEEP : ST_SILENT;
        end
        ST_SILENT, ST_SLEEP: begin
          if (status.wakeEvt) begin
            stateNext = ST_FAILSAFE;
            srcNext   = SRC_LOCAL;
          end else if (status.ignEvt) begin
            stateNext = ST_FAILSAFE;
            srcNext   = SRC_IGNITE;
          end
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.guardStart = (state == ST_NORMAL) && (stateNext == ST_GUARD);
    strobe.guardClear = (state == ST_GUARD) && (stateNext != ST_GUARD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      srcReg <= SRC_NONE;
    end else begin
      state  <= stateNext;
      srcReg <= srcNext;
    end
  end

  always_comb begin
    modeOut = MODE_OFF;
    regEn   = 1'b0;
    xcvrEn  = 1'b0;
    inhEn   = 1'b0;
    wdEn    = 1'b0;
    fsSrc   = SRC_NONE;
    unique case (state)
      ST_FAILSAFE: begin
        modeOut = MODE_FAILSAFE;
        regEn = 1'b1; inhEn = 1'b1; wdEn = 1'b1;
        fsSrc = srcReg;
      end
      ST_NORMAL, ST_GUARD: begin
        modeOut = MODE_NORMAL;
        regEn = 1'b1; xcvrEn = 1'b1; inhEn = 1'b1; wdEn = 1'b1;
      end
      ST_SILENT: begin
        modeOut = MODE_SILENT;
        regEn = 1'b1;
      end
      ST_SLEEP: modeOut = MODE_SLEEP;
      default: modeOut = MODE_OFF;
    endcase
  end
endmodule

// File: rtl/xcvrModeCtrl.sv
module xcvrModeCtrl
  import xcvrModePkg::*;
#(
  parameter int WAKE_DEB  = 5,
  parameter int IGN_DEB   = 9,
  parameter int GUARD_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       resetActive,
  input  logic       enPin,
  input  logic       txdIn,
  input  logic       wakeNIn,
  input  logic       ignIn,
  output logic [2:0] modeOut,
  output logic       regEn,
  output logic       xcvrEn,
  output logic       inhEn,
  output logic       wdEn,
  output logic [1:0] fsSrc
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  modeDatapath #(
    .WAKE_DEB(WAKE_DEB), .IGN_DEB(IGN_DEB), .GUARD_CYC(GUARD_CYC)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .wakeNIn(wakeNIn),
    .ignIn(ignIn), .strobe(strobe), .status(status)
  );

  modeControl u_control (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .resetActive(resetActive),
    .enPin(enPin), .status(status), .strobe(strobe), .modeOut(modeOut),
    .regEn(regEn), .xcvrEn(xcvrEn), .inhEn(inhEn), .wdEn(wdEn), .fsSrc(fsSrc)
  );
endmodule

// File: rtl/xcvrModeCheck.sv
module xcvrModeCheck
  import xcvrModePkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       powerGood,
  input logic       resetActive,
  input logic       enPin,
  input logic [2:0] modeOut,
  input logic [1:0] fsSrc
);
  AST_POWER_LOSS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> modeOut == MODE_OFF); // R2

  AST_ENABLE_TO_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == MODE_FAILSAFE && powerGood && enPin && !resetActive)
      |=> modeOut == MODE_NORMAL); // R3

  AST_RESET_FORCES_FS: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && resetActive && (modeOut == MODE_NORMAL || modeOut == MODE_FAILSAFE))
      |=> modeOut == MODE_FAILSAFE); // R4

  AST_SLEEP_ONLY_FROM_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == MODE_SLEEP && $past(modeOut) != MODE_SLEEP)
      |-> $past(modeOut) == MODE_NORMAL); // R5

  AST_WAKE_LANDS_FS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(modeOut) == MODE_SILENT || $past(modeOut) == MODE_SLEEP)
      && modeOut != $past(modeOut) && $past(powerGood))
      |-> modeOut == MODE_FAILSAFE); // R7

  AST_FS_SOURCE_SET: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == MODE_FAILSAFE |-> fsSrc != SRC_NONE); // R11
endmodule

bind xcvrModeCtrl xcvrModeCheck u_modeCheck (
  .clk(clk), .rstN(rstN), .powerGood(powerGood), .resetActive(resetActive),
  .enPin(enPin), .modeOut(modeOut), .fsSrc(fsSrc)
);

// File: tb/xcvrModeCtrl_bench.sv
`timescale 1ns/1ps
module xcvrModeCtrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDEB = 5;
  localparam int IDEB = 9;
  localparam int GRD  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, powerGood = 1'b0, resetActive = 1'b0;
  logic enPin = 1'b0, txdIn = 1'b1, wakeNIn = 1'b1, ignIn = 1'b0;
  logic [2:0] modeOut;
  logic regEn, xcvrEn, inhEn, wdEn;
  logic [1:0] fsSrc;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvrModeCtrl #(.WAKE_DEB(WDEB), .IGN_DEB(IDEB), .GUARD_CYC(GRD)) u_xcvrModeCtrl (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .resetActive(resetActive),
    .enPin(enPin), .txdIn(txdIn), .wakeNIn(wakeNIn), .ignIn(ignIn),
    .modeOut(modeOut), .regEn(regEn), .xcvrEn(xcvrEn), .inhEn(inhEn),
    .wdEn(wdEn), .fsSrc(fsSrc)
  );

  // behavioural reference: mode codes per R1, guard phase tracked as its own number
  int mMode = 0;      // 0..4 as R1, 5 = normal with guard window open
  int mSrc = 0;
  int wRun = 0, iRun = 0, gCount = 0;
  bit wArm = 0, iArm = 0, wEvt = 0, iEvt = 0, gLow = 0;

  always @(posedge clk) begin
    bit oldW, oldI;
    if (!rstN) begin
      mMode = 0; mSrc = 0; wRun = 0; iRun = 0; gCount = 0;
      wArm = 0; iArm = 0; wEvt = 0; iEvt = 0; gLow = 0;
    end else begin
      oldW = wEvt; oldI = iEvt;
      if (wakeNIn) begin wArm = 1; wRun = 0; wEvt = 0; end
      else if (wArm) begin
        wRun++;
        if (wRun == WDEB) begin wEvt = 1; wArm = 0; wRun = 0; end else wEvt = 0;
      end else wEvt = 0;
      if (!ignIn) begin iArm = 1; iRun = 0; iEvt = 0; end
      else if (iArm) begin
        iRun++;
        if (iRun == IDEB) begin iEvt = 1; iArm = 0; iRun = 0; end else iEvt = 0;
      end else iEvt = 0;

      if (!powerGood) begin
        mMode = 0; gCount = 0; gLow = 0;
      end else begin
        case (mMode)
          0: begin mMode = 1; mSrc = 1; end
          1: if (!resetActive && enPin) mMode = 2;
          2: if (resetActive) mMode = 1;
             else if (!enPin) begin mMode = 5; gCount = 1; gLow = !txdIn; end
          5: if (resetActive) begin mMode = 1; gCount = 0; gLow = 0; end
             else if (enPin) begin mMode = 2; gCount = 0; gLow = 0; end
             else if (gCount == GRD) begin
               mMode = (gLow || !txdIn) ? 4 : 3; gCount = 0; gLow = 0;
             end else begin gLow = gLow || !txdIn; gCount++; end
          3, 4: if (oldW) begin mMode = 1; mSrc = 2; end
                else if (oldI) begin mMode = 1; mSrc = 3; end
          default: mMode = 0;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    int em, er, ex, ei, ew, es;
    em = (mMode == 5) ? 2 : mMode;
    er = (em == 1 || em == 2 || em == 3);
    ex = (em == 2);
    ei = (em == 1 || em == 2);
    ew = (em == 1 || em == 2);
    es = (em == 1) ? mSrc : 0;
    if (!finished) begin
      chk("R1 model mode", modeOut, em);
      chk("R1 model enables", {regEn, xcvrEn, inhEn, wdEn}, {er[0], ex[0], ei[0], ew[0]});
      chk("R11 model source", fsSrc, es);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R2 unpowered mode", modeOut, 0);
    chk("R2 unpowered regEn", regEn, 0);

    powerGood = 1'b1; step(1);
    chk("R2 power-up to fail-safe", modeOut, 1);
    chk("R11 power-up source", fsSrc, 1);
    chk("R1 fail-safe enables", {regEn, xcvrEn, inhEn, wdEn}, 4'b1011);

    enPin = 1'b1; step(1);
    chk("R3 enable to normal", modeOut, 2);
    chk("R1 normal enables", {regEn, xcvrEn, inhEn, wdEn}, 4'b1111);

    resetActive = 1'b1; step(1);
    chk("R4 reset from normal", modeOut, 1);
    chk("R11 reset keeps source", fsSrc, 1);
    step(2);
    chk("R4 reset holds fail-safe", modeOut, 1);
    resetActive = 1'b0; step(1);
    chk("R3 back to normal", modeOut, 2);

    wakeNIn = 1'b0; step(WDEB + 3);
    chk("R12 wake ignored in normal", modeOut, 2);
    wakeNIn = 1'b1; step(1);

    enPin = 1'b0; txdIn = 1'b0; step(GRD);
    chk("R5 normal during guard", modeOut, 2);
    step(1);
    chk("R5 sleep entry", modeOut, 4);
    chk("R1 sleep enables", {regEn, xcvrEn, inhEn, wdEn}, 4'b0000);
    chk("R11 source hidden in sleep", fsSrc, 0);

    resetActive = 1'b1; step(3);
    chk("R4 reset ignored in sleep", modeOut, 4);
    resetActive = 1'b0;

    wakeNIn = 1'b0; step(WDEB - 1); wakeNIn = 1'b1; step(3);
    chk("R7 short wake pulse ignored", modeOut, 4);
    wakeNIn = 1'b0; step(WDEB);
    chk("R7 still asleep before event", modeOut, 4);
    step(1);
    chk("R7 local wake to fail-safe", modeOut, 1);
    chk("R7 local wake source", fsSrc, 2);
    wakeNIn = 1'b1; txdIn = 1'b1;

    enPin = 1'b1; step(1);
    enPin = 1'b0; step(2); txdIn = 1'b0; step(GRD - 1);
    chk("R5 late txd fall picks sleep", modeOut, 4);
    txdIn = 1'b1;

    ignIn = 1'b1; step(IDEB);
    chk("R8 still asleep before event", modeOut, 4);
    step(1);
    chk("R8 ignition wake", modeOut, 1);
    chk("R8 ignition source", fsSrc, 3);

    enPin = 1'b1; step(1);
    enPin = 1'b0; step(GRD + 1);
    chk("R5 silent entry", modeOut, 3);
    chk("R1 silent enables", {regEn, xcvrEn, inhEn, wdEn}, 4'b1000);
    txdIn = 1'b0; step(2);
    chk("R5 txd after window ignored", modeOut, 3);
    txdIn = 1'b1; step(IDEB + 3);
    chk("R9 held ignition no wake", modeOut, 3);

    ignIn = 1'b0; step(1);
    ignIn = 1'b1; step(IDEB - WDEB);
    wakeNIn = 1'b0; step(WDEB);
    chk("R10 before joint event", modeOut, 3);
    step(1);
    chk("R10 joint wake mode", modeOut, 1);
    chk("R10 local wins source", fsSrc, 2);
    wakeNIn = 1'b1; ignIn = 1'b0;

    enPin = 1'b1; step(1);
    wakeNIn = 1'b0; step(WDEB + 2);
    enPin = 1'b0; step(GRD + 1);
    chk("R9 silent with wake held", modeOut, 3);
    step(WDEB + 3);
    chk("R9 held wake no wake", modeOut, 3);
    wakeNIn = 1'b1; step(1);
    wakeNIn = 1'b0; step(WDEB + 1);
    chk("R7 fresh wake from silent", modeOut, 1);
    wakeNIn = 1'b1;

    enPin = 1'b1; step(1);
    enPin = 1'b0; step(1);
    enPin = 1'b1; step(GRD + 3);
    chk("R6 guard cancelled", modeOut, 2);

    enPin = 1'b0; step(1);
    resetActive = 1'b1; step(1);
    chk("R4 reset during guard", modeOut, 1);
    resetActive = 1'b0; step(1);
    chk("R3 enable low stays fail-safe", modeOut, 1);

    powerGood = 1'b0; step(1);
    chk("R2 power loss", modeOut, 0);
    chk("R2 power loss regEn", regEn, 0);

    step(2);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule